// File: doc/BRIEF.md
# Chain Network Route Direction Selector

This block sits in one switch of a linear chain of nodes and decides where a message header goes next. The switch holds its own 16-bit node identifier and a direction table with one 2-bit entry for each identifier bit. For each header, the block XORs the destination identifier with the node identifier. It finds the highest bit that differs and returns the table entry for that bit. When the two identifiers are equal, it returns a local-delivery code instead.

Nodes are numbered in order along the chain with the top identifier bit inverted, so that identifier zero sits in the middle. The default table therefore follows from the node identifier and from the side of the chain the node is on, and is generated in hardware. A configuration port can change the identifier and the side. It can also force any single entry to any code, including an "up" code that sends traffic toward a second switch in the same package, and it can later drop that forced value. Headers enter through a valid/ready handshake. The chosen direction comes out of a result register with its own valid/ready pair.

Top module: `chain_route_sel`

## Requirements
- R1: After reset, res_valid is 0 and hdr_ready is 1. The node identifier equals RESET_ID (default 0x0000) and the side flag equals RESET_RIGHT (default 1, right side).
- R2: A header whose destination equals the node identifier yields res_dir = 2'b11 (local), whatever the table holds.
- R3: Otherwise res_dir is the effective table entry whose index is the position of the highest set bit of (destination XOR node identifier). The codes are 2'b00 left, 2'b01 right, 2'b10 up and 2'b11 local.
- R4: With the side flag at 1 (right side) and no forced value, the entry for bit N is right (01) when bit N of (~id XOR 0x8000) is 1, and left (00) when it is 0.
- R5: With the side flag at 0 (left side) and no forced value, the entry for bit N is right (01) when bit N of the identifier is 1, and left (00) when it is 0.
- R6: A forced entry returns its written 2-bit code, including up (10), in place of the default. Dropping the forced value brings back the default entry.
- R7: A header is accepted when hdr_valid and hdr_ready are both 1. Its result appears with res_valid in the next cycle. hdr_ready equals (!res_valid || res_ready). While res_valid is 1 and res_ready is 0, res_dir holds its value.
- R8: A configuration write becomes effective in the cycle after it. A header accepted in the same cycle as the write is decided with the old settings.
- R9: Reset clears every forced entry, so the table returns to the default generated from the node identifier and the side flag.
- R10: When cfg_we is 1, cfg_op selects the action. 0 loads the identifier from cfg_data. 1 loads the side flag from cfg_data[0]. 2 forces entry cfg_idx to cfg_data[1:0]. 3 drops the forced value of entry cfg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header destination is presented |
| hdr_ready | output | 1 | Block can take a header this cycle |
| hdr_dest | input | 16 | Destination node identifier |
| res_valid | output | 1 | Direction result is valid |
| res_ready | input | 1 | Downstream takes the result |
| res_dir | output | 2 | Direction code: 00 left, 01 right, 10 up, 11 local |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Configuration action (see R10) |
| cfg_idx | input | 4 | Table entry index for actions 2 and 3 |
| cfg_data | input | 16 | Identifier, side flag or entry code |

## Verification
The hardest case to reach is a header accepted in the same cycle as a configuration write that changes its own answer. One example is an identifier change that turns a local match into a forwarded header. Another is forcing the very entry that the header's highest differing bit selects. Random destinations almost never line up with such writes by chance. The stimulus therefore biases destinations toward the current identifier and toward single-bit flips of it, and it issues configuration writes often. A bench model applies each write only after it has decided that cycle's lookup. Directed steps add a forced "up" entry, a reset that must clear it, and writes and lookups in the same cycle on the entry being looked up.

// File: rtl/chain_route_pkg.sv
`timescale 1ns/1ps
package chain_route_pkg;

  // Direction codes carried on res_dir
  localparam logic [1:0] DIR_LEFT  = 2'b00;
  localparam logic [1:0] DIR_RIGHT = 2'b01;
  localparam logic [1:0] DIR_UP    = 2'b10;
  localparam logic [1:0] DIR_LOCAL = 2'b11;

  // Configuration actions carried on cfg_op
  localparam logic [1:0] CFG_SET_ID     = 2'd0;
  localparam logic [1:0] CFG_SET_SIDE   = 2'd1;
  localparam logic [1:0] CFG_PUT_ENTRY  = 2'd2;
  localparam logic [1:0] CFG_DROP_ENTRY = 2'd3;

  // One forced table entry
  typedef struct packed {
    logic       en;
    logic [1:0] code;
  } entry_force_t;

endpackage

// File: rtl/crs_default_gen.sv
`timescale 1ns/1ps
// Builds the default direction bits (1 = right, 0 = left) from the node
// identifier and the side of the chain the node lies on.
module crs_default_gen #(
  parameter int unsigned ID_W = 16
) (
  input  logic [ID_W-1:0] node_id,
  input  logic            side_right,
  output logic [ID_W-1:0] dflt_bits
);

  localparam logic [ID_W-1:0] TOP_MASK = {1'b1, {(ID_W-1){1'b0}}};

  function automatic logic [ID_W-1:0] chain_default(
    input logic [ID_W-1:0] id,
    input logic            right
  );
    if (right) return (~id) ^ TOP_MASK;
    return id;
  endfunction

  assign dflt_bits = chain_default(node_id, side_right);

endmodule

// File: rtl/crs_msb_pick.sv
`timescale 1ns/1ps
// Finds the most significant set bit of a difference vector.
module crs_msb_pick #(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     diff,
  output logic [W-1:0]     pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_any
);

  logic [W-1:0] above;

  assign above[W-1] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < W - 1; g++) begin : g_above
      assign above[g] = above[g+1] | diff[g+1];
    end
    for (g = 0; g < W; g++) begin : g_oh
      assign pick_oh[g] = diff[g] & ~above[g];
    end
  endgenerate

  function automatic logic [IDX_W-1:0] oh_to_index(input logic [W-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (oh[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  assign pick_idx = oh_to_index(pick_oh);
  assign pick_any = |diff;

endmodule

// File: rtl/crs_dir_table.sv
`timescale 1ns/1ps
// Direction table: default bits merged with per-entry forced codes.
module crs_dir_table
  import chain_route_pkg::*;
#(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_put,
  input  logic             wr_drop,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_code,
  input  logic [ID_W-1:0]  dflt_bits,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_code,
  output logic [ID_W-1:0]  force_en_vec
);

  entry_force_t force_q [ID_W];
  logic [1:0]   eff     [ID_W];

  function automatic logic [1:0] merge_entry(
    input entry_force_t f,
    input logic         dflt
  );
    if (f.en) return f.code;
    return dflt ? DIR_RIGHT : DIR_LEFT;
  endfunction

  genvar g;
  generate
    for (g = 0; g < ID_W; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          force_q[g] <= '0;
        end else if (wr_idx == IDX_W'(g)) begin
          if (wr_put) begin
            force_q[g].en   <= 1'b1;
            force_q[g].code <= wr_code;
          end else if (wr_drop) begin
            force_q[g].en   <= 1'b0;
          end
        end
      end
      assign eff[g]          = merge_entry(force_q[g], dflt_bits[g]);
      assign force_en_vec[g] = force_q[g].en;
    end
  endgenerate

  assign rd_code = eff[rd_idx];

endmodule

// File: rtl/chain_route_sel.sv
`timescale 1ns/1ps
// Route direction selector for one switch of a linear node chain.
module chain_route_sel
  import chain_route_pkg::*;
#(
  parameter int unsigned     ID_W        = 16,
  parameter logic [ID_W-1:0] RESET_ID    = '0,
  parameter logic            RESET_RIGHT = 1'b1,
  localparam int unsigned    IDX_W       = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [ID_W-1:0]  hdr_dest,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [1:0]       res_dir,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_op,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [ID_W-1:0]  cfg_data
);

  // Node settings
  logic [ID_W-1:0] node_id_q;
  logic            side_right_q;

  // Named internal events
  logic            accept;
  logic            set_id, set_side, put_entry, drop_entry;
  logic [ID_W-1:0] diff;
  logic [ID_W-1:0] pick_oh;
  logic [IDX_W-1:0] pick_idx;
  logic            pick_any;
  logic [ID_W-1:0] dflt_bits;
  logic [ID_W-1:0] force_en_vec;
  logic [1:0]      table_code;
  logic [1:0]      lookup_dir;

  assign set_id     = cfg_we && (cfg_op == CFG_SET_ID);
  assign set_side   = cfg_we && (cfg_op == CFG_SET_SIDE);
  assign put_entry  = cfg_we && (cfg_op == CFG_PUT_ENTRY);
  assign drop_entry = cfg_we && (cfg_op == CFG_DROP_ENTRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_id_q    <= RESET_ID;
      side_right_q <= RESET_RIGHT;
    end else begin
      if (set_id)   node_id_q    <= cfg_data;
      if (set_side) side_right_q <= cfg_data[0];
    end
  end

  crs_default_gen #(.ID_W(ID_W)) u_dflt (
    .node_id    (node_id_q),
    .side_right (side_right_q),
    .dflt_bits  (dflt_bits)
  );

  crs_dir_table #(.ID_W(ID_W), .IDX_W(IDX_W)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_put       (put_entry),
    .wr_drop      (drop_entry),
    .wr_idx       (cfg_idx),
    .wr_code      (cfg_data[1:0]),
    .dflt_bits    (dflt_bits),
    .rd_idx       (pick_idx),
    .rd_code      (table_code),
    .force_en_vec (force_en_vec)
  );

  assign diff = hdr_dest ^ node_id_q;

  crs_msb_pick #(.W(ID_W), .IDX_W(IDX_W)) u_pick (
    .diff     (diff),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .pick_any (pick_any)
  );

  assign lookup_dir = pick_any ? table_code : DIR_LOCAL;

  // Result register with its own handshake
  assign hdr_ready = !res_valid || res_ready;
  assign accept    = hdr_valid && hdr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_dir   <= DIR_LOCAL;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_dir   <= lookup_dir;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/chain_route_sel_chk.sv
`timescale 1ns/1ps
module chain_route_sel_chk #(
  parameter int unsigned ID_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic [ID_W-1:0] hdr_dest,
  input logic [ID_W-1:0] node_id,
  input logic            res_valid,
  input logic            res_ready,
  input logic [1:0]      res_dir,
  input logic [ID_W-1:0] pick_oh,
  input logic [ID_W-1:0] force_en,
  input logic            cfg_we,
  input logic [1:0]      cfg_op,
  input logic [ID_W-1:0] cfg_data
);

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_dir))); // R7

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && (!res_valid || res_ready)) |=> !res_valid); // R7

  AST_LOCAL_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (hdr_dest == node_id)) |=> (res_dir == 2'b11)); // R2

  AST_SINGLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh)); // R3

  AST_RESET_CLEARS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (force_en == '0)); // R9

  AST_ID_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_op == 2'd0)) |=> (node_id == $past(cfg_data))); // R10

endmodule

bind chain_route_sel chain_route_sel_chk #(.ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .hdr_dest  (hdr_dest),
  .node_id   (node_id_q),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_dir   (res_dir),
  .pick_oh   (pick_oh),
  .force_en  (force_en_vec),
  .cfg_we    (cfg_we),
  .cfg_op    (cfg_op),
  .cfg_data  (cfg_data)
);

// File: tb/chain_route_sel_bench.sv
`timescale 1ns/1ps
module chain_route_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [15:0] hdr_dest = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_dir;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_op = '0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;

  always #5 clk = ~clk;

  chain_route_sel u_chain_route_sel (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dest(hdr_dest), .res_valid(res_valid), .res_ready(res_ready),
    .res_dir(res_dir), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model of the node settings
  logic [15:0] m_id;
  logic        m_right;
  logic        m_fen  [16];
  logic [1:0]  m_fcode[16];
  // Expected result register
  logic        exp_valid;
  logic [1:0]  exp_dir;
  string       exp_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [1:0] ref_dir(input logic [15:0] dest);
    int hi;
    hi = 0;
    if (dest == m_id) return 2'b11;
    for (int b = 0; b < 16; b++) if (dest[b] != m_id[b]) hi = b;
    if (m_fen[hi]) return m_fcode[hi];
    if (m_right) return (hi == 15) ? {1'b0, m_id[hi]} : {1'b0, ~m_id[hi]};
    return {1'b0, m_id[hi]};
  endfunction

  function automatic string ref_tag(input logic [15:0] dest);
    int hi;
    hi = 0;
    if (dest == m_id) return "R2";
    for (int b = 0; b < 16; b++) if (dest[b] != m_id[b]) hi = b;
    if (m_fen[hi]) return "R3/R6";
    return m_right ? "R3/R4" : "R3/R5";
  endfunction

  task automatic model_reset();
    m_id = 16'h0000; m_right = 1'b1;
    for (int i = 0; i < 16; i++) begin m_fen[i] = 1'b0; m_fcode[i] = 2'b00; end
    exp_valid = 1'b0; exp_dir = 2'b11; exp_tag = "R1";
  endtask

  // One cycle: check last edge's result, drive inputs, update the model.
  task automatic step(input bit hv, input logic [15:0] dest, input bit rr,
                      input bit we, input logic [1:0] op, input logic [3:0] idx,
                      input logic [15:0] data, input string extra);
    bit rdy;
    @(negedge clk);
    chk(res_valid == exp_valid, "R7", "res_valid", res_valid, exp_valid);
    if (exp_valid)
      chk(res_dir == exp_dir, exp_tag, "res_dir", res_dir, exp_dir);
    hdr_valid = hv; hdr_dest = dest; res_ready = rr;
    cfg_we = we; cfg_op = op; cfg_idx = idx; cfg_data = data;
    #1;
    rdy = !exp_valid || rr;
    chk(hdr_ready == rdy, "R7", "hdr_ready", hdr_ready, rdy);
    // Lookup uses settings before this cycle's write (R8)
    if (hv && rdy) begin
      exp_valid = 1'b1;
      exp_dir   = ref_dir(dest);
      exp_tag   = (extra != "") ? extra : ref_tag(dest);
    end else if (rr) begin
      exp_valid = 1'b0;
    end
    if (we) begin  // R10 action encoding
      case (op)
        2'd0: m_id = data;
        2'd1: m_right = data[0];
        2'd2: begin m_fen[idx] = 1'b1; m_fcode[idx] = data[1:0]; end
        default: m_fen[idx] = 1'b0;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hdr_valid = 0; res_ready = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    #1;
    chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
    chk(hdr_ready == 1'b1, "R1", "hdr_ready after reset", hdr_ready, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R1/R4: reset identifier 0000 on the right side
    step(1, 16'h8000, 1, 0, 0, 0, 0, "R1/R4");  // bit15 -> left
    step(1, 16'h0001, 1, 0, 0, 0, 0, "R1/R4");  // bit0 -> right
    step(1, 16'h0000, 1, 0, 0, 0, 0, "R2");
    // R5: left-side node
    step(0, 0, 1, 1, 2'd1, 0, 16'h0000, "");
    step(0, 0, 1, 1, 2'd0, 0, 16'hA5C3, "");
    step(1, 16'hA5C2, 1, 0, 0, 0, 0, "R5");
    step(1, 16'h25C3, 1, 0, 0, 0, 0, "R5");
    // R6: force bit-0 entry to up, then drop it
    step(1, 16'hA5C2, 1, 1, 2'd2, 4'd0, 16'h0002, "R8");  // same-cycle: old entry
    step(1, 16'hA5C2, 1, 0, 0, 0, 0, "R6");
    step(1, 16'hA5C2, 1, 1, 2'd3, 4'd0, 0, "R6/R8");
    step(1, 16'hA5C2, 1, 0, 0, 0, 0, "R6");
    // R8: identifier change in the same cycle as a matching lookup
    step(1, 16'hA5C3, 1, 1, 2'd0, 0, 16'h1234, "R8");
    step(1, 16'hA5C3, 1, 0, 0, 0, 0, "R8");
    // R7: stall holds the result
    step(1, 16'h1235, 0, 0, 0, 0, 0, "R7");
    step(1, 16'hFFFF, 0, 0, 0, 0, 0, "R7");
    step(1, 16'hFFFF, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 0, 0, "");
    // R9: forced entry then reset
    step(0, 0, 1, 1, 2'd2, 4'd15, 16'h0002, "");
    do_reset();
    step(1, 16'h8000, 1, 0, 0, 0, 0, "R9");

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] d;
      logic [15:0] cd;
      int sel;
      bit we;
      logic [1:0] op;
      logic [3:0] ix;
      sel = $urandom_range(0, 99);
      if (sel < 25) d = m_id;
      else if (sel < 70) d = m_id ^ (16'h1 << $urandom_range(0, 15));
      else d = 16'($urandom);
      we = ($urandom_range(0, 5) == 0);
      op = 2'($urandom_range(0, 3));
      ix = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 5))
        0: cd = 16'h0000;
        1: cd = 16'h8000;
        2: cd = 16'hFFFF;
        3: cd = 16'h7FFF;
        default: cd = 16'($urandom);
      endcase
      if (op == 2'd2 && $urandom_range(0, 1) == 1) begin ix = 4'd0; cd = 16'h0002; end
      step($urandom_range(0, 3) != 0, d, $urandom_range(0, 3) != 0,
           we, op, ix, cd, "");
    end
    step(0, 0, 1, 0, 0, 0, 0, "");
    step(0, 0, 1, 0, 0, 0, 0, "");
    finish_run();
  end

endmodule